// File: doc/BRIEF.md
# Segmented DAC Thermometer Switch Decoder

This block is the digital front end of an 8-bit current-steering converter whose cell array is fully unary. A straight binary sample is registered on each rising clock edge, split into an upper field and a lower field, and each field is expanded into a thermometer vector. Every bit of those vectors drives one current cell: a set bit steers the cell to the true output, a cleared bit steers it to the complementary output. The upper field drives 31 equal segments; the lower field drives 7 equal units, each worth one eighth of a segment. The true-side current therefore follows code/256 and the complementary side (255 - code)/256.

The decoded vectors sit in a second register stage, so all switch lines change together and at a fixed latency of two clocks after the sample is presented. A sleep input, active high, drops the cell-enable output and freezes the switch vectors. When sleep goes low again, the block resumes with the most recently captured sample.

Top module: `seg_dac_decoder`

## Requirements
- R1: `code_i` is straight binary with bit 7 as MSB; the upper field is `code_i[7:3]` and the lower field is `code_i[2:0]`.
- R2: With sleep low, a sample presented before rising edge n appears on `seg_o`/`unit_o` after edge n+1 and not after edge n.
- R3: Bit i of `seg_o` (i = 0..30) is 1 exactly when the registered upper field is greater than i.
- R4: Bit i of `unit_o` (i = 0..6) is 1 exactly when the registered lower field is greater than i.
- R5: 8 x (ones in `seg_o`) + (ones in `unit_o`) equals the registered code; code 255 sets every bit of both vectors and code 0 clears every bit.
- R6: While `rst_ni` is low, asynchronously and without a clock edge, both vectors are all zero and `cell_en_o` is 0.
- R7: After a rising edge at which `sleep_i` is 1, `cell_en_o` is 0 and both vectors keep their values; a code change during sleep has no effect on the vectors.
- R8: After a rising edge at which `sleep_i` is 0, `cell_en_o` is 1; on the first such edge after sleep the vectors show the code captured at the edge before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | 8 | Binary sample, bit 7 most significant |
| sleep_i | input | 1 | Power-down request, active high |
| seg_o | output | 31 | Thermometer vector for the segment cells |
| unit_o | output | 7 | Thermometer vector for the unit cells |
| cell_en_o | output | 1 | Cell enable, low during sleep and reset |

## Verification
The code-sum property assumes `code_i` is a known value at every sampled edge once two edges have passed after reset, and that the sample it compares was not taken during reset; the bench drives `code_i` to a defined value before releasing reset and only changes it on falling edges. The sleep properties assume `sleep_i` is stable around rising edges, which the bench keeps by toggling it only on falling edges. The sweep over all 256 codes drives each value long enough for the two-stage pipeline to settle before any output is compared.

// File: rtl/seg_dac_pkg.sv
`timescale 1ns/1ps
package seg_dac_pkg;
    // Default field split of the sample word
    parameter int unsigned DEF_MSB_BITS = 5;
    parameter int unsigned DEF_LSB_BITS = 3;

    // Number of cells a thermometer field of the given width drives
    function automatic int unsigned cells_for(input int unsigned bits);
        return (1 << bits) - 1;
    endfunction
endpackage

// File: rtl/dac_sample_reg.sv
`timescale 1ns/1ps
module dac_sample_reg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] code_i,
    output logic [DATA_W-1:0] code_o
);
    typedef struct packed {
        logic [DATA_W-1:0] code;
    } smp_state_t;

    smp_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.code = code_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;
endmodule

// File: rtl/dac_thermo_dec.sv
`timescale 1ns/1ps
module dac_thermo_dec #(
    parameter int unsigned IN_W  = 5,
    localparam int unsigned OUT_N = (1 << IN_W) - 1
) (
    input  logic [IN_W-1:0]  bin_i,
    output logic [OUT_N-1:0] therm_o
);
    // Fill from index 0 upward: cell i on when the field exceeds i
    for (genvar i = 0; i < OUT_N; i++) begin : g_cell
        assign therm_o[i] = (bin_i > IN_W'(i));
    end
endmodule

// File: rtl/dac_switch_reg.sv
`timescale 1ns/1ps
module dac_switch_reg #(
    parameter int unsigned SEG_N  = 31,
    parameter int unsigned UNIT_N = 7
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sleep_i,
    input  logic [SEG_N-1:0]  seg_i,
    input  logic [UNIT_N-1:0] unit_i,
    output logic [SEG_N-1:0]  seg_o,
    output logic [UNIT_N-1:0] unit_o,
    output logic              en_o
);
    typedef struct packed {
        logic [SEG_N-1:0]  seg;
        logic [UNIT_N-1:0] unit;
        logic              en;
    } sw_state_t;

    sw_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = ~sleep_i;
        if (!sleep_i) begin
            st_d.seg  = seg_i;
            st_d.unit = unit_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign seg_o  = st_q.seg;
    assign unit_o = st_q.unit;
    assign en_o   = st_q.en;
endmodule

// File: rtl/seg_dac_decoder.sv
`timescale 1ns/1ps
module seg_dac_decoder
    import seg_dac_pkg::*;
#(
    parameter int unsigned MSB_BITS = DEF_MSB_BITS,
    parameter int unsigned LSB_BITS = DEF_LSB_BITS,
    localparam int unsigned DATA_W  = MSB_BITS + LSB_BITS,
    localparam int unsigned SEG_N   = (1 << MSB_BITS) - 1,
    localparam int unsigned UNIT_N  = (1 << LSB_BITS) - 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] code_i,
    input  logic              sleep_i,
    output logic [SEG_N-1:0]  seg_o,
    output logic [UNIT_N-1:0] unit_o,
    output logic              cell_en_o
);
    logic [DATA_W-1:0]   code_q;
    logic [MSB_BITS-1:0] upper_w;
    logic [LSB_BITS-1:0] lower_w;
    logic [SEG_N-1:0]    seg_next;
    logic [UNIT_N-1:0]   unit_next;

    dac_sample_reg #(.DATA_W(DATA_W)) u_sample (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .code_i (code_i),
        .code_o (code_q)
    );

    // Field split: upper bits feed segments, lower bits feed units
    assign upper_w = code_q[DATA_W-1 -: MSB_BITS];
    assign lower_w = code_q[LSB_BITS-1:0];

    dac_thermo_dec #(.IN_W(MSB_BITS)) u_seg_dec (
        .bin_i   (upper_w),
        .therm_o (seg_next)
    );

    dac_thermo_dec #(.IN_W(LSB_BITS)) u_unit_dec (
        .bin_i   (lower_w),
        .therm_o (unit_next)
    );

    dac_switch_reg #(.SEG_N(SEG_N), .UNIT_N(UNIT_N)) u_switch (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sleep_i (sleep_i),
        .seg_i   (seg_next),
        .unit_i  (unit_next),
        .seg_o   (seg_o),
        .unit_o  (unit_o),
        .en_o    (cell_en_o)
    );
endmodule

// File: rtl/seg_dac_decoder_chk.sv
`timescale 1ns/1ps
module seg_dac_decoder_chk #(
    parameter int unsigned MSB_BITS = 5,
    parameter int unsigned LSB_BITS = 3,
    localparam int unsigned DATA_W  = MSB_BITS + LSB_BITS,
    localparam int unsigned SEG_N   = (1 << MSB_BITS) - 1,
    localparam int unsigned UNIT_N  = (1 << LSB_BITS) - 1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [DATA_W-1:0] code_i,
    input logic              sleep_i,
    input logic [SEG_N-1:0]  seg_o,
    input logic [UNIT_N-1:0] unit_o,
    input logic              cell_en_o
);
    logic [1:0] warm_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            warm_q <= '0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    AST_SEG_THERMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((seg_o & (seg_o + SEG_N'(1))) == '0)); // R3

    AST_UNIT_THERMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((unit_o & (unit_o + UNIT_N'(1))) == '0)); // R4

    AST_CODE_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (warm_q >= 2'd2 && !sleep_i) |=>
        (($countones(seg_o) * (1 << LSB_BITS) + $countones(unit_o)) == int'($past(code_i, 2)))); // R5

    AST_SLEEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sleep_i |=> ($stable(seg_o) && $stable(unit_o) && !cell_en_o)); // R7

    AST_WAKE_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sleep_i |=> cell_en_o); // R8
endmodule

bind seg_dac_decoder seg_dac_decoder_chk #(
    .MSB_BITS(MSB_BITS),
    .LSB_BITS(LSB_BITS)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .code_i    (code_i),
    .sleep_i   (sleep_i),
    .seg_o     (seg_o),
    .unit_o    (unit_o),
    .cell_en_o (cell_en_o)
);

// File: tb/test_seg_dac_decoder.sv
`timescale 1ns/1ps
module test_seg_dac_decoder;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [7:0]  code_i = 8'd0;
    logic        sleep_i = 1'b0;
    logic [30:0] seg_o;
    logic [6:0]  unit_o;
    logic        cell_en_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    seg_dac_decoder i_seg_dac_decoder (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .code_i    (code_i),
        .sleep_i   (sleep_i),
        .seg_o     (seg_o),
        .unit_o    (unit_o),
        .cell_en_o (cell_en_o)
    );

    always #5 clk_i = ~clk_i;

    function automatic logic [30:0] exp_seg(input logic [7:0] c);
        logic [30:0] r;
        for (int i = 0; i < 31; i++) r[i] = (int'(c >> 3) > i);
        return r;
    endfunction

    function automatic logic [6:0] exp_unit(input logic [7:0] c);
        logic [6:0] r;
        for (int i = 0; i < 7; i++) r[i] = (int'(c & 8'h07) > i);
        return r;
    endfunction

    function automatic int ones(input logic [30:0] v);
        int n = 0;
        for (int i = 0; i < 31; i++) n += int'(v[i]);
        return n;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_code(input string req, input logic [7:0] c);
        chk(seg_o === exp_seg(c), req, longint'(seg_o), longint'(exp_seg(c)));
        chk(unit_o === exp_unit(c), req, longint'(unit_o), longint'(exp_unit(c)));
    endtask

    task automatic settle(input logic [7:0] c);
        @(negedge clk_i) code_i = c;
        @(negedge clk_i);
        @(negedge clk_i);
    endtask

    task automatic t_reset();
        @(negedge clk_i);
        chk(seg_o === '0, "R6 seg in reset", longint'(seg_o), 0);
        chk(unit_o === '0, "R6 unit in reset", longint'(unit_o), 0);
        chk(cell_en_o === 1'b0, "R6 enable in reset", longint'(cell_en_o), 0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk(cell_en_o === 1'b1, "R8 enable after reset", longint'(cell_en_o), 1);
    endtask

    task automatic t_sweep();
        for (int c = 0; c < 256; c++) begin
            settle(8'(c));
            chk_code("R3 R4 sweep", 8'(c));
            chk(ones(seg_o) * 8 + ones({24'd0, unit_o}) == c, "R5 R1 weight sum",
                ones(seg_o) * 8 + ones({24'd0, unit_o}), c);
        end
    endtask

    task automatic t_extremes();
        settle(8'd255);
        chk(seg_o === '1 && unit_o === '1, "R5 full scale", longint'({seg_o, unit_o}), 38'h3F_FFFF_FFFF);
        settle(8'd0);
        chk(seg_o === '0 && unit_o === '0, "R5 zero scale", longint'({seg_o, unit_o}), 0);
        settle(8'd8);
        chk(seg_o === 31'd1 && unit_o === 7'd0, "R1 bit3 is segment lsb", longint'({seg_o, unit_o}), 38'h80);
        settle(8'd7);
        chk(seg_o === 31'd0 && unit_o === 7'h7F, "R1 low field only", longint'({seg_o, unit_o}), 38'h7F);
    endtask

    task automatic t_latency();
        settle(8'h15);
        @(negedge clk_i) code_i = 8'hEA;
        @(negedge clk_i);
        chk_code("R2 unchanged after first edge", 8'h15);
        @(negedge clk_i);
        chk_code("R2 updated after second edge", 8'hEA);
    endtask

    task automatic t_sleep();
        settle(8'h9C);
        @(negedge clk_i) sleep_i = 1'b1;
        @(negedge clk_i);
        chk(cell_en_o === 1'b0, "R7 enable low in sleep", longint'(cell_en_o), 0);
        chk_code("R7 hold at sleep entry", 8'h9C);
        code_i = 8'h31;
        @(negedge clk_i);
        @(negedge clk_i);
        chk_code("R7 code ignored in sleep", 8'h9C);
        code_i = 8'hF3;
        @(negedge clk_i) sleep_i = 1'b0;
        @(negedge clk_i);
        chk(cell_en_o === 1'b1, "R8 enable after wake", longint'(cell_en_o), 1);
        chk_code("R8 wake shows last captured code", 8'hF3);
    endtask

    task automatic t_async_reset();
        settle(8'hFF);
        @(negedge clk_i);
        #2 rst_ni = 1'b0;
        #1;
        chk(seg_o === '0 && unit_o === '0, "R6 async clear", longint'({seg_o, unit_o}), 0);
        chk(cell_en_o === 1'b0, "R6 async enable low", longint'(cell_en_o), 0);
        @(negedge clk_i) rst_ni = 1'b1;
        @(negedge clk_i);
        chk_code("R6 reset restarts from code 0", 8'h00);
    endtask

    initial begin
        t_reset();
        t_extremes();
        t_latency();
        t_sleep();
        t_sweep();
        t_async_reset();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100us;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule